// File: doc/BRIEF.md
# DMA Parameter Staging Registers

This block holds the transfer parameters of one channel of a block-cipher accelerator's DMA path: a source address, a destination address and a byte count. Software writes these through a simple register port. The values it writes go to a staged set. A separate active set feeds the DMA mover. Because the two sets are separate, software can program the next job, or the next cascade round, while the current one is still running.

The active set is loaded from the staged set at two moments only. The first is an accepted start while the channel is idle. The second is the end of a cascade round when cascading is enabled and the round that just ended was not marked as the final one. A halt request or a bus error reported by the mover ends the job at once. A bus error also sets a sticky fault flag, which is cleared at the next accepted start. The cipher core, the bus master and the mover itself lie outside this block.

Register map (word addresses on `reg_addr`):
- 0 control
- 1 status
- 2 staged source
- 3 staged destination
- 4 staged count

Top module: `dma_param_stage`

## Requirements
- R1: After reset the status register reads 0 (bit 0 busy clear, bit 1 fault clear), `busy` is 0, and the three active outputs and the three staged registers are all 0.
- R2: A write to address 2, 3 or 4 stores the full 32-bit value, including the low address bits. A read of that address returns the stored staged value, not the active copy.
- R3: While idle, writing the control register (address 0) with bit 0 (go) set makes `busy` high after that clock edge. In the same edge the active set loads the staged set. The two active addresses have bits 1:0 forced to 0. The count is copied with all 32 bits, so 0xFFFFFFFF is kept.
- R4: While busy, writes to addresses 2 to 4 leave the active outputs unchanged. The written values are applied at the next load.
- R5: Equal source and destination addresses are loaded as they are, and they do not set the fault flag.
- R6: When control bit 2 (chain) is set, a `round_done` pulse while busy loads the active set from the staged set and keeps `busy` high. This holds unless the running round was marked final.
- R7: Control bit 3 (final) is captured when a round begins, that is, at start or at a chain reload. When a round captured with final set ends, `busy` falls and no reload happens.
- R8: With the chain bit clear, a `round_done` pulse while busy ends the job and does not change the active outputs.
- R9: A `bus_err` pulse while busy clears `busy` and sets status bit 1. The flag stays set through other register writes and is cleared only by the next accepted start.
- R10: Reading the control register returns 0 in bits 1:0 (go and halt). Bits 2 and 3 return the stored chain and final settings.
- R11: Writing control bit 1 (halt) while busy clears `busy` at the next edge. A later `round_done` pulse then causes no reload.
- R12: A go written while busy is ignored: the active outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for writes |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read data (combinational) |
| round_done | input | 1 | End of the current round, from the mover |
| bus_err | input | 1 | Bus error pulse from the mover |
| busy | output | 1 | Job in progress |
| act_load | output | 1 | Pulse: the active set was reloaded this cycle |
| act_src | output | 32 | Active source address, word aligned |
| act_dst | output | 32 | Active destination address, word aligned |
| act_cnt | output | 32 | Active byte count |

## Verification
The hardest state to reach from the ports is a cascade chain in which each round picks up freshly staged values. In that chain, the final mark has to be captured at a reload rather than at the start. The stimulus starts a chained job and restages all three parameters mid-round. It ends the round to force a reload, then sets the final bit and restages again before the next boundary. The bench then checks that the active values follow each stage and that the third boundary ends the job without loading. A halt inside a chained round, followed by a stray `round_done`, shows that the pending reload was dropped.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int REG_AW  = 3;
  localparam int DW      = 32;
  localparam int NPAR    = 3;
  localparam int PAR_BASE = 2;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_SRC  = 3'd2,
    A_DST  = 3'd3,
    A_CNT  = 3'd4
  } reg_addr_e;

  localparam int C_GO    = 0;
  localparam int C_HALT  = 1;
  localparam int C_CHAIN = 2;
  localparam int C_FINAL = 3;
endpackage

// File: rtl/dps_staging.sv
module dps_staging
  import dps_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic              busy,
  input  logic              fault,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] stg_src,
  output logic [DATA_W-1:0] stg_dst,
  output logic [DATA_W-1:0] stg_cnt,
  output logic              chain_nx,
  output logic              final_nx,
  output logic              go_req,
  output logic              halt_req
);
  logic [DATA_W-1:0] stg_q [NPAR];
  logic              chain_q, final_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  // one staged word per parameter, each with its own write enable
  for (genvar g = 0; g < NPAR; g++) begin : g_par
    logic              we;
    logic [DATA_W-1:0] d;
    assign we = wr_en && (wr_addr == REG_AW'(PAR_BASE + g));
    always_comb d = we ? wr_data : stg_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= d;
    end
  end

  always_comb begin
    chain_nx = ctrl_wr ? wr_data[C_CHAIN] : chain_q;
    final_nx = ctrl_wr ? wr_data[C_FINAL] : final_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 1'b0;
      final_q <= 1'b0;
    end else begin
      chain_q <= chain_nx;
      final_q <= final_nx;
    end
  end

  assign go_req   = ctrl_wr && wr_data[C_GO];
  assign halt_req = ctrl_wr && wr_data[C_HALT];
  assign stg_src  = stg_q[0];
  assign stg_dst  = stg_q[1];
  assign stg_cnt  = stg_q[2];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[C_CHAIN] = chain_q;
        rd_data[C_FINAL] = final_q;
      end
      A_STAT: rd_data[1:0] = {fault, busy};
      A_SRC:  rd_data = stg_q[0];
      A_DST:  rd_data = stg_q[1];
      A_CNT:  rd_data = stg_q[2];
      default: rd_data = '0;
    endcase
  end

  // R10: strobe bits never read back as 1
  p_ctrl_strobes_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CTRL) |-> (rd_data[C_HALT:C_GO] == 2'b00));
  // R2: a write to a parameter register is visible in its staged word next cycle
  p_stage_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CNT) |=> (stg_cnt == $past(wr_data)));
endmodule

// File: rtl/dps_seq.sv
module dps_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic halt_req,
  input  logic round_done,
  input  logic bus_err,
  input  logic chain_nx,
  input  logic final_nx,
  output logic busy,
  output logic fault,
  output logic load
);
  logic busy_q, busy_d;
  logic fault_q, fault_d;
  logic last_q, last_d;

  always_comb begin
    busy_d  = busy_q;
    fault_d = fault_q;
    last_d  = last_q;
    load    = 1'b0;
    if (busy_q) begin
      if (halt_req) begin
        busy_d = 1'b0;
      end else if (bus_err) begin
        busy_d  = 1'b0;
        fault_d = 1'b1;
      end else if (round_done) begin
        if (last_q || !chain_nx) begin
          busy_d = 1'b0;
        end else begin
          load   = 1'b1;
          last_d = final_nx;
        end
      end
    end else if (go_req && !halt_req) begin
      load    = 1'b1;
      busy_d  = 1'b1;
      fault_d = 1'b0;
      last_d  = final_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fault_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      fault_q <= fault_d;
      last_q  <= last_d;
    end
  end

  assign busy  = busy_q;
  assign fault = fault_q;

  // R11: halt drops busy at the next edge
  p_halt_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && halt_req) |=> !busy_q);
  // R9: bus error stops the job and raises the flag
  p_buserr_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_err && !halt_req) |=> (fault_q && !busy_q));
  // R9: the flag only falls on a load (accepted start)
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !load) |=> fault_q);
  // R12: no load from a go while busy without a round boundary
  p_go_busy_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !round_done) |-> !load);
endmodule

// File: rtl/dps_active.sv
module dps_active
  import dps_pkg::*;
#(
  parameter int DATA_W  = DW,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] stg_src,
  input  logic [DATA_W-1:0] stg_dst,
  input  logic [DATA_W-1:0] stg_cnt,
  output logic [DATA_W-1:0] act_src,
  output logic [DATA_W-1:0] act_dst,
  output logic [DATA_W-1:0] act_cnt
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'((1 << ALIGN_W) - 1);

  logic [DATA_W-1:0] src_d, dst_d, cnt_d;

  always_comb begin
    src_d = act_src;
    dst_d = act_dst;
    cnt_d = act_cnt;
    if (load) begin
      src_d = stg_src & ALIGN_MASK;
      dst_d = stg_dst & ALIGN_MASK;
      cnt_d = stg_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_src <= '0;
      act_dst <= '0;
      act_cnt <= '0;
    end else begin
      act_src <= src_d;
      act_dst <= dst_d;
      act_cnt <= cnt_d;
    end
  end

  // R4: outside a load the active set does not move
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_src) && $stable(act_dst) && $stable(act_cnt)));
  // R3: the count is taken whole from the staged word
  p_count_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_cnt == $past(stg_cnt)));
endmodule

// File: rtl/dma_param_stage.sv
module dma_param_stage
  import dps_pkg::*;
#(
  parameter int DATA_W  = DW,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              round_done,
  input  logic              bus_err,
  output logic              busy,
  output logic              act_load,
  output logic [DATA_W-1:0] act_src,
  output logic [DATA_W-1:0] act_dst,
  output logic [DATA_W-1:0] act_cnt
);
  logic [DATA_W-1:0] stg_src, stg_dst, stg_cnt;
  logic chain_nx, final_nx, go_req, halt_req, fault;

  dps_staging #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .rd_addr(rd_addr), .busy(busy), .fault(fault),
    .rd_data(rd_data), .stg_src(stg_src), .stg_dst(stg_dst),
    .stg_cnt(stg_cnt), .chain_nx(chain_nx), .final_nx(final_nx),
    .go_req(go_req), .halt_req(halt_req)
  );

  dps_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .halt_req(halt_req),
    .round_done(round_done), .bus_err(bus_err), .chain_nx(chain_nx),
    .final_nx(final_nx), .busy(busy), .fault(fault), .load(act_load)
  );

  dps_active #(.DATA_W(DATA_W), .ALIGN_W(ALIGN_W)) u_act (
    .clk(clk), .rst_n(rst_n), .load(act_load), .stg_src(stg_src),
    .stg_dst(stg_dst), .stg_cnt(stg_cnt), .act_src(act_src),
    .act_dst(act_dst), .act_cnt(act_cnt)
  );

  // R6: a chain reload keeps the job running
  p_chain_keeps_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && act_load) |=> busy);
endmodule

// File: tb/test_dma_param_stage.sv
`timescale 1ns/1ps
module test_dma_param_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        round_done, bus_err, busy, act_load;
  logic [31:0] act_src, act_dst, act_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_param_stage i_dma_param_stage (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .round_done(round_done), .bus_err(bus_err), .busy(busy),
    .act_load(act_load), .act_src(act_src), .act_dst(act_dst),
    .act_cnt(act_cnt)
  );

  // stimulus src, dst, cnt, expected active src, expected active dst
  localparam logic [31:0] VEC [4][5] = '{
    '{32'h1000_0003, 32'h2000_0001, 32'h0000_0040, 32'h1000_0000, 32'h2000_0000},
    '{32'h3000_0010, 32'h3000_0010, 32'h0000_0008, 32'h3000_0010, 32'h3000_0010},
    '{32'hFFFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 32'h0000_0000},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic pulse_done();
    @(negedge clk); round_done = 1'b1;
    @(negedge clk); round_done = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0;
  endtask

  task automatic stage(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr(3'd2, s); wr(3'd3, d); wr(3'd4, c);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rd_addr = '0; round_done = 1'b0; bus_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, r); chk("R1 status", r, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 act_src", act_src, 0);
    chk("R1 act_dst", act_dst, 0);
    chk("R1 act_cnt", act_cnt, 0);
    rd(3'd4, r); chk("R1 staged cnt", r, 0);

    // table walk: R2 R3 R5 R8
    for (int i = 0; i < 4; i++) begin
      stage(VEC[i][0], VEC[i][1], VEC[i][2]);
      rd(3'd2, r); chk("R2 staged src readback", r, VEC[i][0]);
      rd(3'd3, r); chk("R2 staged dst readback", r, VEC[i][1]);
      wr(3'd0, 32'h1);
      chk("R3 busy after go", {31'b0, busy}, 1);
      chk("R3 active src aligned", act_src, VEC[i][3]);
      chk("R3 active dst aligned", act_dst, VEC[i][4]);
      chk("R3 active cnt full", act_cnt, VEC[i][2]);
      rd(3'd1, r); chk("R5 no fault", r, 32'h1);
      pulse_done();
      chk("R8 unchained round ends job", {31'b0, busy}, 0);
      chk("R8 active unchanged", act_cnt, VEC[i][2]);
    end

    // R4 / R12: writes and go while busy
    stage(32'h4000_0000, 32'h4100_0000, 32'h100);
    wr(3'd0, 32'h1);
    stage(32'h5555_5557, 32'h6666_6664, 32'h200);
    chk("R4 active src held", act_src, 32'h4000_0000);
    chk("R4 active cnt held", act_cnt, 32'h100);
    rd(3'd2, r); chk("R2 staged differs from active", r, 32'h5555_5557);
    wr(3'd0, 32'h1);
    chk("R12 go while busy ignored", act_src, 32'h4000_0000);
    chk("R12 busy stays", {31'b0, busy}, 1);
    pulse_done();
    wr(3'd0, 32'h1);
    chk("R4 applied at next start src", act_src, 32'h5555_5554);
    chk("R4 applied at next start cnt", act_cnt, 32'h200);
    pulse_done();

    // R6 / R7 / R10 cascade chain
    stage(32'h7000_0000, 32'h7100_0000, 32'h10);
    wr(3'd0, 32'h5);
    rd(3'd0, r); chk("R10 ctrl readback", r, 32'h4);
    stage(32'h7200_0000, 32'h7300_0000, 32'h20);
    pulse_done();
    chk("R6 busy kept over round", {31'b0, busy}, 1);
    chk("R6 reload src", act_src, 32'h7200_0000);
    chk("R6 reload cnt", act_cnt, 32'h20);
    wr(3'd0, 32'hC);
    rd(3'd0, r); chk("R10 ctrl readback final", r, 32'hC);
    stage(32'h7400_0000, 32'h7500_0000, 32'h30);
    pulse_done();
    chk("R7 last round still busy", {31'b0, busy}, 1);
    chk("R7 last round loaded", act_dst, 32'h7500_0000);
    stage(32'h7600_0000, 32'h7700_0000, 32'h40);
    pulse_done();
    chk("R7 busy falls after final round", {31'b0, busy}, 0);
    chk("R7 no reload after final", act_cnt, 32'h30);

    // R11 halt inside a chained job
    wr(3'd0, 32'h5);
    chk("R11 job running", {31'b0, busy}, 1);
    stage(32'h7800_0000, 32'h7900_0000, 32'h50);
    wr(3'd0, 32'h6);
    chk("R11 halt clears busy", {31'b0, busy}, 0);
    pulse_done();
    chk("R11 no reload after halt", act_src, 32'h7600_0000);
    rd(3'd0, r); chk("R10 halt reads zero", r, 32'h4);

    // R9 bus error
    wr(3'd0, 32'h1);
    pulse_err();
    chk("R9 busy cleared by bus error", {31'b0, busy}, 0);
    rd(3'd1, r); chk("R9 fault set", r, 32'h2);
    stage(32'h1, 32'h2, 32'h3);
    rd(3'd1, r); chk("R9 fault sticky over writes", r, 32'h2);
    wr(3'd0, 32'h1);
    rd(3'd1, r); chk("R9 fault cleared by start", r, 32'h1);
    pulse_done();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule